// File: doc/BRIEF.md
# Prioritized Interrupt Type Responder

This block sits between a set of device request lines and a processor that takes one interrupt request input and runs a two-pulse acknowledge cycle. Each request line latches a pending bit. While any bit is pending and no acknowledge is under way, the block raises a single interrupt request output. The processor answers with two active-low acknowledge pulses. On the first pulse the block chooses the pending request with the lowest index and holds that choice. During the second pulse it drives the 8-bit vector type of that request onto the data bus, with the output enable high.

The type of each request comes from a table parameter. When nothing valid is left to deliver, the block drives a spurious type instead. When the second pulse ends, the pending bit of the delivered request is cleared. A separate clear input lets each device withdraw its request at any time. All inputs are synchronous to the block clock.

Top module: `irq_type_responder`

## Requirements
- R1: While reset is low, and on the first cycle after it, the interrupt request output is low, the bus enable is low and the acknowledge sequencer is idle.
- R2: A request line sampled high at a clock edge sets its pending bit. The bit stays set after the line drops, and the interrupt request output is high whenever any bit is pending, acknowledge is high and no sequence is in progress.
- R3: The interrupt request output is low in every cycle in which acknowledge is low, and throughout a sequence from its first pulse until the second pulse ends.
- R4: The bus enable is high only while acknowledge is low during the second pulse of a sequence. At all other times it is low, including during the first pulse and between the pulses.
- R5: During the second pulse the bus carries the table type of the lowest-index request that was pending when the first pulse began. The default table gives request 0 type 0xD0, request 1 type 0x0C, request 2 type 0x40 and request 3 type 0x41.
- R6: A request that arrives after the first pulse, even one of higher priority, does not change the byte driven in the second pulse.
- R7: When the second pulse ends, the pending bit of the delivered request is cleared, unless its line is still high at that edge. Other pending requests stay pending and raise the interrupt request output again.
- R8: A high clear bit removes that pending bit at the next edge, and it wins over a request on the same line in the same cycle.
- R9: If nothing was pending at the first pulse, or the captured request was cleared before the second pulse began, the bus carries the spurious type 0xFF.
- R10: A falling acknowledge edge starts a first pulse when the sequencer is idle and a second pulse after a first. The sequencer goes back to idle when the second pulse ends, so the next falling edge is again a first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_REQ | Device request lines, index 0 highest priority |
| clr_i | input | N_REQ | Per-request clear of the pending bit |
| inta_n_i | input | 1 | Active-low interrupt acknowledge from the processor |
| intr_o | output | 1 | Combined interrupt request to the processor |
| bus_d_o | output | TYPE_W | Type byte toward the data bus, zero when not enabled |
| bus_oe_o | output | 1 | Bus output enable; low means the bus is left high-impedance |

## Verification
A wrong pulse count shows up at the ports on the next acknowledge edge. The bus enable then opens during the first pulse or fails to open in the second, and the interrupt request output stays low after the sequence should have closed. A wrong captured index or validity flag shows up only as a wrong byte in the second pulse, so the bench drives arrivals and clears between the pulses. A pending bit that is left set or lost by mistake shows up one cycle after the sequence, as an interrupt request that should or should not be there. The bench models the pending set and the pulse count and compares the request line, the enable and the byte every cycle.

// File: rtl/irq_resp_pkg.sv
// Package irq_resp_pkg
// Shared encodings for the interrupt type responder.
// Assumes every user imports it before declaring sequencer state.
package irq_resp_pkg;

    // Acknowledge sequence position: idle, inside/after pulse one, pulse two.
    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_ONE  = 2'd1,
        ACK_TWO  = 2'd2
    } ack_st_t;

    // Type driven when no valid request remains to be delivered.
    localparam logic [7:0] SPURIOUS_TYPE = 8'hFF;

endpackage

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick
// Fixed-priority selector: reports the lowest set index of the pending
// vector and whether any bit is set. Purely combinational.
// Assumes N_REQ >= 2 so that the index width is at least one bit.
module irq_prio_pick #(
    parameter int N_REQ = 4,
    localparam int IW   = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] pend_i,
    output logic [IW-1:0]    idx_o,
    output logic             any_o
);

    // Scan from the lowest priority upward so the lowest index wins last.
    always_comb begin
        idx_o = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
        any_o = |pend_i;
    end

endmodule

// File: rtl/irq_ack_seq.sv
// Module irq_ack_seq
// Counts the two acknowledge pulses, captures the winning request at the
// first pulse and checks at the second pulse that it is still pending.
// Assumes inta_n_i is already synchronous to clk.
module irq_ack_seq
    import irq_resp_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int IW   = $clog2(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta_n_i,
    input  logic [IW-1:0]    win_idx_i,
    input  logic             win_any_i,
    input  logic [N_REQ-1:0] pend_i,
    output logic             idle_o,
    output logic             drive_o,
    output logic             done_o,
    output logic [IW-1:0]    cap_idx_o,
    output logic             dlv_vld_o
);

    ack_st_t       st_q;
    logic          prev_q;
    logic [IW-1:0] cap_q;
    logic          capv_q;
    logic          dv_q;
    logic          ack_fall;
    logic          ack_rise;

    // Edge detection on the acknowledge input against its last sample.
    always_comb begin
        ack_fall = prev_q & ~inta_n_i;
        ack_rise = ~prev_q & inta_n_i;
    end

    // Pulse counter, capture of the winner and delivery validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ACK_IDLE;
            prev_q <= 1'b1;
            cap_q  <= '0;
            capv_q <= 1'b0;
            dv_q   <= 1'b0;
        end else begin
            prev_q <= inta_n_i;
            case (st_q)
                ACK_IDLE: if (ack_fall) begin
                    st_q   <= ACK_ONE;
                    cap_q  <= win_idx_i;
                    capv_q <= win_any_i;
                end
                ACK_ONE: if (ack_fall) begin
                    st_q <= ACK_TWO;
                    dv_q <= capv_q & pend_i[cap_q];
                end
                ACK_TWO: if (ack_rise) st_q <= ACK_IDLE;
                default: st_q <= ACK_IDLE;
            endcase
        end
    end

    // Status toward the top level.
    always_comb begin
        idle_o    = (st_q == ACK_IDLE);
        drive_o   = (st_q == ACK_TWO) & ~inta_n_i;
        done_o    = (st_q == ACK_TWO) & ack_rise;
        cap_idx_o = cap_q;
        dlv_vld_o = dv_q;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q == ACK_IDLE) && prev_q);

    // R4
    bus_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> !inta_n_i && !idle_o);

    // R10
    seq_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> idle_o);

    // R10
    second_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACK_ONE) && ack_fall |=> (st_q == ACK_TWO));

endmodule

// File: rtl/irq_type_responder.sv
// Module irq_type_responder
// Latches device requests, raises one combined interrupt request and, on
// the second acknowledge pulse, drives the type of the request captured
// at the first pulse. The bus enable stands in for the tri-state control.
// Assumes all inputs are synchronous to clk; request 0 has top priority.
module irq_type_responder
    import irq_resp_pkg::*;
#(
    parameter int                        N_REQ      = 4,
    parameter int                        TYPE_W     = 8,
    parameter logic [N_REQ*TYPE_W-1:0]   TYPE_TABLE = {8'h41, 8'h40, 8'h0C, 8'hD0},
    parameter logic [TYPE_W-1:0]         SPUR_TYPE  = TYPE_W'(SPURIOUS_TYPE),
    localparam int                       IW         = $clog2(N_REQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req_i,
    input  logic [N_REQ-1:0]  clr_i,
    input  logic              inta_n_i,
    output logic              intr_o,
    output logic [TYPE_W-1:0] bus_d_o,
    output logic              bus_oe_o
);

    logic [N_REQ-1:0]  pend_q;
    logic [N_REQ-1:0]  dlv_mask;
    logic [IW-1:0]     win_idx;
    logic              win_any;
    logic              idle;
    logic              done;
    logic [IW-1:0]     cap_idx;
    logic              dlv_vld;
    logic [TYPE_W-1:0] type_arr [N_REQ];

    irq_prio_pick #(.N_REQ(N_REQ)) u_pick (
        .pend_i (pend_q),
        .idx_o  (win_idx),
        .any_o  (win_any)
    );

    irq_ack_seq #(.N_REQ(N_REQ)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta_n_i  (inta_n_i),
        .win_idx_i (win_idx),
        .win_any_i (win_any),
        .pend_i    (pend_q),
        .idle_o    (idle),
        .drive_o   (bus_oe_o),
        .done_o    (done),
        .cap_idx_o (cap_idx),
        .dlv_vld_o (dlv_vld)
    );

    // Per-request slice of the type table and delivery clear mask.
    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        assign type_arr[g] = TYPE_TABLE[g*TYPE_W +: TYPE_W];
        assign dlv_mask[g] = done & dlv_vld & (cap_idx == IW'(g));
    end

    // Pending bits: set by request, dropped by clear or by delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i & ~dlv_mask) | (req_i & ~clr_i);
    end

    // Combined request and bus byte.
    always_comb begin
        intr_o  = (|pend_q) & idle & inta_n_i;
        bus_d_o = '0;
        if (bus_oe_o) bus_d_o = dlv_vld ? type_arr[cap_idx] : SPUR_TYPE;
    end

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(req_i) & ~$past(clr_i) & ~pend_q) == '0));

    // R3
    intr_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_i |-> !intr_o);

    // R7
    dlv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && dlv_vld |=> !pend_q[$past(cap_idx)] || $past(req_i[cap_idx]));

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));

    // R4
    bus_off_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !intr_o);

endmodule

// File: tb/irq_type_responder_tb.sv
module irq_type_responder_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] clr = '0;
    logic         inta_n = 1'b1;
    logic         intr;
    logic [7:0]   bus_d;
    logic         bus_oe;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // bench model of the requirements
    logic [N-1:0] m_pend = '0;
    int           m_st = 0;
    logic         m_prev = 1'b1;
    int           m_cap = 0;
    logic         m_capv = 1'b0;
    logic         m_dv = 1'b0;

    always #10 clk = ~clk;

    irq_type_responder u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .clr_i(clr),
        .inta_n_i(inta_n), .intr_o(intr), .bus_d_o(bus_d), .bus_oe_o(bus_oe)
    );

    function automatic logic [7:0] tbl(input int i);
        case (i)
            0: return 8'hD0;
            1: return 8'h0C;
            2: return 8'h40;
            default: return 8'h41;
        endcase
    endfunction

    function automatic int lowest(input logic [N-1:0] p);
        for (int i = N - 1; i >= 0; i--) if (p[i]) lowest = i;
        if (p == '0) lowest = 0;
    endfunction

    function automatic logic exp_intr();
        return (m_pend != '0) && (m_st == 0) && inta_n;
    endfunction

    function automatic logic exp_oe();
        return (m_st == 2) && !inta_n;
    endfunction

    function automatic logic [7:0] exp_data();
        return m_dv ? tbl(m_cap) : 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // apply inputs, check outputs, advance model across one edge
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] c,
                        input logic ia, input string tag);
        logic fall, rise;
        logic [N-1:0] dm;
        req = r; clr = c; inta_n = ia;
        #1;
        chk({tag, " intr"}, intr, exp_intr());
        chk({tag, " oe"}, bus_oe, exp_oe());
        if (exp_oe()) chk({tag, " data"}, bus_d, exp_data());
        @(posedge clk);
        fall = m_prev & ~ia;
        rise = ~m_prev & ia;
        dm = '0;
        if (m_st == 2 && rise && m_dv) dm[m_cap] = 1'b1;
        case (m_st)
            0: if (fall) begin m_st = 1; m_cap = lowest(m_pend); m_capv = (m_pend != '0); end
            1: if (fall) begin m_st = 2; m_dv = m_capv & m_pend[m_cap]; end
            default: if (rise) m_st = 0;
        endcase
        m_pend = (m_pend & ~c & ~dm) | (r & ~c);
        m_prev = ia;
        @(negedge clk);
    endtask

    task automatic ack_seq(input string tag, input logic [N-1:0] mid, input logic [N-1:0] midclr);
        step('0, '0, 1'b1, tag);
        step('0, '0, 1'b0, tag);
        step('0, '0, 1'b0, tag);
        step(mid, midclr, 1'b1, tag);
        step('0, '0, 1'b1, tag);
        step('0, '0, 1'b0, tag);
        step('0, '0, 1'b0, tag);
        step('0, '0, 1'b1, tag);
        step('0, '0, 1'b1, tag);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ia;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 intr", intr, 1'b0);
        chk("R1 oe", bus_oe, 1'b0);
        rst_n = 1'b1;
        step('0, '0, 1'b1, "R1");

        // R2 latch and hold
        step(4'b0010, '0, 1'b1, "R2");
        step('0, '0, 1'b1, "R2");
        chk("R2 held", intr, 1'b1);
        // R5 single request, type 0x0C; R7 cleared after
        ack_seq("R5", '0, '0);
        chk("R7 cleared", intr, 1'b0);

        // R5 priority 0 over 2, then R7 remaining one
        step(4'b0101, '0, 1'b1, "R5");
        ack_seq("R5", '0, '0);
        chk("R7 remaining", intr, 1'b1);
        ack_seq("R7", '0, '0);
        chk("R7 empty", intr, 1'b0);

        // R6 higher priority arrives between pulses
        step(4'b0100, '0, 1'b1, "R6");
        ack_seq("R6", 4'b0001, '0);
        ack_seq("R6", '0, '0);

        // R9 nothing pending, then captured request withdrawn
        ack_seq("R9", '0, '0);
        step(4'b1000, '0, 1'b1, "R9");
        ack_seq("R9", '0, 4'b1000);
        chk("R9 after", intr, 1'b0);

        // R8 clear beats request
        step(4'b0010, 4'b0010, 1'b1, "R8");
        step('0, '0, 1'b1, "R8");
        chk("R8 none", intr, 1'b0);
        step(4'b0001, '0, 1'b1, "R8");
        step('0, 4'b0001, 1'b1, "R8");
        step('0, '0, 1'b1, "R8");

        // R3 intr drops when acknowledge goes low
        step(4'b0001, '0, 1'b1, "R3");
        step('0, '0, 1'b0, "R3");
        chk("R3 low", intr, 1'b0);
        step('0, '0, 1'b1, "R3");
        step('0, '0, 1'b0, "R3");
        step('0, '0, 1'b1, "R3");

        // R10 back-to-back sequences
        step(4'b1010, '0, 1'b1, "R10");
        ack_seq("R10", '0, '0);
        ack_seq("R10", '0, '0);

        // R4 random traffic
        ia = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0] r, c;
            r = (($urandom % 4) == 0) ? N'($urandom) : '0;
            c = (($urandom % 8) == 0) ? N'($urandom) : '0;
            if (($urandom % 3) == 0) ia = ~ia;
            step(r, c, ia, "R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule